// File: doc/BRIEF.md
# Multi-Channel DMA Request Sequencer

This block lets up to `NCH` I/O channels share one direct-memory-access path into a host memory. Each channel raises a break request when it wants a word moved. The sequencer picks one channel, raises a memory request towards the host, and then walks that channel through a sync time state, an address time state and a data time state. Each time state is marked by two phase strobes, `a_phase` early and `d_phase` late. Each channel tells the block whether it runs in fast mode and whether it supplies data (input) or receives it (output). The host answers with a sync acknowledge level, and later with grant and strobe pulses that time the loading of an external data register.

A channel that keeps its break request raised through its first data transfer is synced again before that transfer ends. The sync of the next word therefore runs under the data transfer of the current one. A channel that has not asked for fast mode gets a slow flag. The slow flag holds the data-ready pulse back by one extra time state, which gives slow logic time for its data lines to settle. All sequencing outputs are single-clock pulses. They are registered and appear in the cycle after the phase strobe that causes them. The data-path selects are level signals.

Top module: `dma_req_seq`

## Requirements
- R1: While `pwr_clr` is high at a clock edge, every channel's sync, address-phase, data-phase, device-control and slow flags are cleared. After that edge `mem_req` and all pulse and select outputs are 0, and a later phase strobe produces no pulse until a new break request is accepted.
- R2: On a `d_phase` strobe a channel's sync flag sets when its break request is high, its slow flag is clear and the arbiter allows it.
- R3: `mem_req` is high exactly while at least one channel's sync flag is set. Its rising edge can therefore only follow a `d_phase` strobe.
- R4: On an `a_phase` strobe with sync set, the channel's address-phase flag sets. If `host_sync_ack` is also high, sync clears and a one-clock `fast_clr` pulse goes to that channel.
- R5: On a `d_phase` strobe with the address-phase flag set and `host_sync_ack` high, the data-phase flag sets. On an `a_phase` strobe with both flags set, an `addr_acc` pulse is issued and the device-control flag sets.
- R6: On a `d_phase` strobe with the data-phase flag set and the slow flag clear, a `data_rdy` pulse is issued. In the same cycle `data_acc` pulses only if the channel's `dir_in` is 1 (device supplies data) and its `inhibit` is 0.
- R7: If `fast_rq` is 0 for a channel whose sync flag is set when `mem_req` rises, its slow flag sets. The slow flag blocks `data_rdy`, so a slow transfer issues `data_rdy` one time state later than a fast one.
- R8: On an `a_phase` strobe the address-phase flag clears when sync is clear and the data-phase flag is set, and the slow flag clears when the address-phase flag is clear and the data-phase flag is set. On a `d_phase` strobe the data-phase flag clears, together with device control, when the address-phase and slow flags are both clear. This ends the sequence.
- R9: A fast channel that holds its break request re-sets sync on the `d_phase` strobe of its first sync-acknowledged time state. On the next `a_phase` strobe it issues `fast_clr` for word two in the same cycle as `addr_acc` for word one, then issues `data_rdy` twice and `addr_acc` twice.
- R10: At most one sync flag is set at a time. With several requests and no sequence running, the lowest-numbered channel wins. While any channel has a flag set, only that channel may set sync.
- R11: `addr_sel[i]` = data-phase flag AND NOT device control. `data_sel[i]` = data-phase flag AND device control AND `dir_in[i]`. `sa_sel` = `host_strobe` AND some channel with its data-phase flag set and `dir_in` 0. `reg_load` = (`host_grant` OR `host_strobe`) AND some data-phase flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_clr | input | 1 | Synchronous power clear, active high |
| a_phase | input | 1 | Early phase strobe of a time state |
| d_phase | input | 1 | Late phase strobe of a time state |
| host_sync_ack | input | 1 | Host has synced to the memory request |
| host_grant | input | 1 | Host grant pulse |
| host_strobe | input | 1 | Host memory strobe pulse |
| brk_rq | input | NCH | Per-channel break request |
| fast_rq | input | NCH | Per-channel fast-mode request |
| dir_in | input | NCH | 1 = channel supplies data to memory |
| inhibit | input | NCH | Suppress data-accept pulse |
| mem_req | output | 1 | Memory access request to host |
| fast_clr | output | NCH | Sync-cleared pulse per channel |
| addr_acc | output | NCH | Address-accepted pulse per channel |
| data_rdy | output | NCH | Data-ready pulse per channel |
| data_acc | output | NCH | Data-accepted pulse per channel |
| dev_ctl | output | NCH | Device-control flag per channel |
| addr_sel | output | NCH | Gate channel address onto register |
| data_sel | output | NCH | Gate channel data onto register |
| sa_sel | output | 1 | Gate memory read data onto register |
| reg_load | output | 1 | Load strobe for the data register |

## Verification
In back-to-back fast transfers, the sync clear of word two and the address accept of word one both fall on the same `a_phase` strobe. The same `d_phase` strobe then re-sets the data-phase flag and issues `data_rdy` for word one. The bench provokes this by holding the break request raised through the second sync acknowledge. It then expects `fast_clr` and `addr_acc` together in one sample, followed by two `data_rdy` pulses on consecutive `d_phase` strobes. A second collision case is arbitration. Two requests arrive on one `d_phase`, and the loser must stay off `mem_req` until the winner's data-phase flag has dropped.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef struct packed {
    logic sync;
    logic set_a;
    logic set_d;
    logic dev_ctl;
    logic slow;
  } chan_flags_t;
endpackage

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0] want,
  input  logic [NCH-1:0] busy,
  output logic [NCH-1:0] allow
);
  logic [NCH-1:0] lower_any;
  logic           acc;
  logic           any_busy;

  always_comb begin
    acc = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      lower_any[i] = acc;
      acc          = acc | want[i];
    end
  end

  assign any_busy = |busy;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_allow
      // A running sequence keeps ownership; otherwise lowest index wins.
      assign allow[g] = want[g] & (any_busy ? busy[g] : ~lower_any[g]);
    end
  endgenerate
endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
(
  input  logic clk,
  input  logic pwr_clr,
  input  logic a_phase,
  input  logic d_phase,
  input  logic sync_ack,
  input  logic req_rise,
  input  logic brk,
  input  logic fast,
  input  logic dir_in,
  input  logic inhibit,
  input  logic allow,
  output logic want,
  output logic busy,
  output logic sync_o,
  output logic set_d_o,
  output logic dev_ctl_o,
  output logic fclr_o,
  output logic aacc_o,
  output logic drdy_o,
  output logic dacc_o
);
  chan_flags_t st;

  assign want      = brk & ~st.slow;
  assign busy      = st.sync | st.set_a | st.set_d | st.slow;
  assign sync_o    = st.sync;
  assign set_d_o   = st.set_d;
  assign dev_ctl_o = st.dev_ctl;

  always_ff @(posedge clk) begin
    if (pwr_clr) begin
      st     <= '0;
      fclr_o <= 1'b0;
      aacc_o <= 1'b0;
      drdy_o <= 1'b0;
      dacc_o <= 1'b0;
    end else begin
      fclr_o <= 1'b0;
      aacc_o <= 1'b0;
      drdy_o <= 1'b0;
      dacc_o <= 1'b0;
      if (d_phase) begin
        if (allow) st.sync <= 1'b1;
        if (st.set_a && sync_ack) begin
          st.set_d <= 1'b1;
        end else if (st.set_d && !st.set_a && !st.slow) begin
          st.set_d   <= 1'b0;
          st.dev_ctl <= 1'b0;
        end
        if (st.set_d && !st.slow) begin
          drdy_o <= 1'b1;
          dacc_o <= dir_in & ~inhibit;
        end
      end
      if (a_phase) begin
        if (st.sync) st.set_a <= 1'b1;
        else if (st.set_d) st.set_a <= 1'b0;
        if (st.sync && sync_ack) begin
          st.sync <= 1'b0;
          fclr_o  <= 1'b1;
        end
        if (st.set_a && st.set_d) begin
          aacc_o     <= 1'b1;
          st.dev_ctl <= 1'b1;
        end
        if (!st.set_a && st.set_d) st.slow <= 1'b0;
      end
      if (req_rise && st.sync && !fast) st.slow <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_seq_dpsel.sv
module dma_seq_dpsel #(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0] set_d,
  input  logic [NCH-1:0] dev_ctl,
  input  logic [NCH-1:0] dir_in,
  input  logic           grant,
  input  logic           strobe,
  output logic [NCH-1:0] addr_sel,
  output logic [NCH-1:0] data_sel,
  output logic           sa_sel,
  output logic           reg_load
);
  assign addr_sel = set_d & ~dev_ctl;
  assign data_sel = set_d & dev_ctl & dir_in;
  assign sa_sel   = strobe & (|(set_d & ~dir_in));
  assign reg_load = (grant | strobe) & (|set_d);
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           pwr_clr,
  input  logic           a_phase,
  input  logic           d_phase,
  input  logic           host_sync_ack,
  input  logic           host_grant,
  input  logic           host_strobe,
  input  logic [NCH-1:0] brk_rq,
  input  logic [NCH-1:0] fast_rq,
  input  logic [NCH-1:0] dir_in,
  input  logic [NCH-1:0] inhibit,
  output logic           mem_req,
  output logic [NCH-1:0] fast_clr,
  output logic [NCH-1:0] addr_acc,
  output logic [NCH-1:0] data_rdy,
  output logic [NCH-1:0] data_acc,
  output logic [NCH-1:0] dev_ctl,
  output logic [NCH-1:0] addr_sel,
  output logic [NCH-1:0] data_sel,
  output logic           sa_sel,
  output logic           reg_load
);
  logic [NCH-1:0] want_vec;
  logic [NCH-1:0] busy_vec;
  logic [NCH-1:0] allow_vec;
  logic [NCH-1:0] sync_vec;
  logic [NCH-1:0] set_d_vec;
  logic           req_q;
  logic           req_rise;

  assign mem_req  = |sync_vec;
  assign req_rise = mem_req & ~req_q;

  always_ff @(posedge clk) begin
    if (pwr_clr) req_q <= 1'b0;
    else         req_q <= mem_req;
  end

  dma_seq_arb #(.NCH(NCH)) u_arb (
    .want (want_vec),
    .busy (busy_vec),
    .allow(allow_vec)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      dma_seq_chan u_chan (
        .clk      (clk),
        .pwr_clr  (pwr_clr),
        .a_phase  (a_phase),
        .d_phase  (d_phase),
        .sync_ack (host_sync_ack),
        .req_rise (req_rise),
        .brk      (brk_rq[g]),
        .fast     (fast_rq[g]),
        .dir_in   (dir_in[g]),
        .inhibit  (inhibit[g]),
        .allow    (allow_vec[g]),
        .want     (want_vec[g]),
        .busy     (busy_vec[g]),
        .sync_o   (sync_vec[g]),
        .set_d_o  (set_d_vec[g]),
        .dev_ctl_o(dev_ctl[g]),
        .fclr_o   (fast_clr[g]),
        .aacc_o   (addr_acc[g]),
        .drdy_o   (data_rdy[g]),
        .dacc_o   (data_acc[g])
      );
    end
  endgenerate

  dma_seq_dpsel #(.NCH(NCH)) u_dpsel (
    .set_d   (set_d_vec),
    .dev_ctl (dev_ctl),
    .dir_in  (dir_in),
    .grant   (host_grant),
    .strobe  (host_strobe),
    .addr_sel(addr_sel),
    .data_sel(data_sel),
    .sa_sel  (sa_sel),
    .reg_load(reg_load)
  );
endmodule

// File: rtl/dma_req_seq_chk.sv
module dma_req_seq_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           pwr_clr,
  input logic           a_phase,
  input logic           d_phase,
  input logic           host_sync_ack,
  input logic           mem_req,
  input logic [NCH-1:0] fast_clr,
  input logic [NCH-1:0] addr_acc,
  input logic [NCH-1:0] data_rdy,
  input logic [NCH-1:0] data_acc,
  input logic [NCH-1:0] dev_ctl,
  input logic [NCH-1:0] sync_vec
);
  assert_clear_R1: assert property (@(posedge clk)
    pwr_clr |=> (!mem_req && dev_ctl == '0 && fast_clr == '0 && data_rdy == '0));

  assert_req_rise_R3: assert property (@(posedge clk) disable iff (pwr_clr)
    $rose(mem_req) |-> $past(d_phase));

  assert_fclr_R4: assert property (@(posedge clk) disable iff (pwr_clr)
    (fast_clr != '0) |-> $past(a_phase && host_sync_ack));

  assert_aacc_R5: assert property (@(posedge clk) disable iff (pwr_clr)
    (addr_acc != '0) |-> $past(a_phase));

  assert_drdy_R6: assert property (@(posedge clk) disable iff (pwr_clr)
    (data_rdy != '0) |-> $past(d_phase));

  assert_dacc_R6: assert property (@(posedge clk) disable iff (pwr_clr)
    (data_acc & ~data_rdy) == '0);

  assert_one_sync_R10: assert property (@(posedge clk) disable iff (pwr_clr)
    $onehot0(sync_vec));
endmodule

bind dma_req_seq dma_req_seq_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .pwr_clr      (pwr_clr),
  .a_phase      (a_phase),
  .d_phase      (d_phase),
  .host_sync_ack(host_sync_ack),
  .mem_req      (mem_req),
  .fast_clr     (fast_clr),
  .addr_acc     (addr_acc),
  .data_rdy     (data_rdy),
  .data_acc     (data_acc),
  .dev_ctl      (dev_ctl),
  .sync_vec     (sync_vec)
);

// File: tb/dma_req_seq_bench.sv
module dma_req_seq_bench;
  localparam int NCH = 3;
  localparam int NV  = 24;

  logic clk = 1'b0;
  logic pwr_clr = 1'b1;
  logic a_phase = 1'b0, d_phase = 1'b0;
  logic host_sync_ack = 1'b0, host_grant = 1'b0, host_strobe = 1'b0;
  logic [NCH-1:0] brk_rq = '0, fast_rq = '0, dir_in = '0, inhibit = '0;
  logic mem_req, sa_sel, reg_load;
  logic [NCH-1:0] fast_clr, addr_acc, data_rdy, data_acc, dev_ctl, addr_sel, data_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dma_req_seq #(.NCH(NCH)) u_dma_req_seq (
    .clk(clk), .pwr_clr(pwr_clr), .a_phase(a_phase), .d_phase(d_phase),
    .host_sync_ack(host_sync_ack), .host_grant(host_grant), .host_strobe(host_strobe),
    .brk_rq(brk_rq), .fast_rq(fast_rq), .dir_in(dir_in), .inhibit(inhibit),
    .mem_req(mem_req), .fast_clr(fast_clr), .addr_acc(addr_acc), .data_rdy(data_rdy),
    .data_acc(data_acc), .dev_ctl(dev_ctl), .addr_sel(addr_sel), .data_sel(data_sel),
    .sa_sel(sa_sel), .reg_load(reg_load)
  );

  // {is_d, brk0, fast0, dir0, inh0, ack, exp{mem,fclr,aacc,drdy,dacc}, req number}
  localparam logic [15:0] VEC [NV] = '{
    // single fast input
    16'b1_1_1_1_0_0_10000_00010, // R2
    16'b0_1_1_1_0_1_01000_00100, // R4
    16'b1_0_1_1_0_1_00000_00101, // R5
    16'b0_0_1_1_0_1_00100_00101, // R5
    16'b1_0_1_1_0_0_00011_00110, // R6
    // single slow output
    16'b1_1_0_0_0_0_10000_00111, // R7
    16'b0_1_0_0_0_1_01000_00100, // R4
    16'b1_0_0_0_0_1_00000_00101, // R5
    16'b0_0_0_0_0_1_00100_00101, // R5
    16'b1_0_0_0_0_0_00000_00111, // R7 held back
    16'b0_0_0_0_0_0_00000_01000, // R8 slow clears
    16'b1_0_0_0_0_0_00010_00111, // R7
    // back-to-back fast output
    16'b1_1_1_0_0_0_10000_00010, // R2
    16'b0_1_1_0_0_1_01000_00100, // R4
    16'b1_1_1_0_0_1_10000_01001, // R9 re-sync
    16'b0_1_1_0_0_1_01100_01001, // R9 overlap
    16'b1_0_1_0_0_1_00010_01001, // R9
    16'b0_0_1_0_0_1_00100_01001, // R9
    16'b1_0_1_0_0_0_00010_01000, // R8
    // fast input, inhibited
    16'b1_1_1_1_1_0_10000_00010, // R2
    16'b0_1_1_1_1_1_01000_00100, // R4
    16'b1_0_1_1_1_1_00000_00101, // R5
    16'b0_0_1_1_1_1_00100_00101, // R5
    16'b1_0_1_1_1_0_00010_00110  // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One phase strobe; returns at the negedge after the strobe edge, then idles a cycle later.
  task automatic strobe(input bit is_d);
    @(negedge clk);
    a_phase = !is_d;
    d_phase = is_d;
    @(negedge clk);
    a_phase = 1'b0;
    d_phase = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    pwr_clr = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs",
        {mem_req, fast_clr, addr_acc, data_rdy, data_acc, dev_ctl, addr_sel, data_sel},
        '0);

    // Vector table walk on channel 0
    for (int k = 0; k < NV; k++) begin
      logic [15:0] v;
      v = VEC[k];
      brk_rq        = {2'b00, v[14]};
      fast_rq       = {2'b00, v[13]};
      dir_in        = {2'b00, v[12]};
      inhibit       = {2'b00, v[11]};
      host_sync_ack = v[10];
      strobe(v[15]);
      chk($sformatf("R%0d vector %0d", v[4:0], k),
          {mem_req, fast_clr[0], addr_acc[0], data_rdy[0], data_acc[0]}, v[9:5]);
      idle();
    end

    // R1: power clear in the middle of a sequence
    host_sync_ack = 1'b0;
    brk_rq = 3'b001; fast_rq = 3'b001; dir_in = '0; inhibit = '0;
    strobe(1'b1);
    idle();
    @(negedge clk); pwr_clr = 1'b1;
    @(negedge clk); pwr_clr = 1'b0;
    chk("R1 mem_req after clear", mem_req, 1'b0);
    brk_rq = '0; host_sync_ack = 1'b1;
    strobe(1'b0);
    chk("R1 no fast_clr after clear", fast_clr, '0);
    idle();
    strobe(1'b1);
    chk("R1 no data_rdy after clear", {mem_req, data_rdy}, '0);
    idle();

    // R10 / R11: two requests, channel 0 (output) wins, channel 1 (input) waits
    host_sync_ack = 1'b0;
    brk_rq = 3'b011; fast_rq = 3'b011; dir_in = 3'b010;
    strobe(1'b1);
    chk("R10 request on contention", mem_req, 1'b1);
    idle();
    host_sync_ack = 1'b1;
    strobe(1'b0);
    chk("R10 lowest channel wins", fast_clr, 3'b001);
    idle();
    brk_rq = 3'b010;
    strobe(1'b1);
    chk("R10 loser held off", mem_req, 1'b0);
    chk("R11 address select", addr_sel, 3'b001);
    idle();
    host_strobe = 1'b1;
    #1;
    chk("R11 sense select and load", {sa_sel, reg_load}, 2'b11);
    host_strobe = 1'b0;
    strobe(1'b0);
    chk("R5 addr_acc ch0", addr_acc, 3'b001);
    chk("R11 device control ch0", {dev_ctl, data_sel}, {3'b001, 3'b000});
    idle();
    strobe(1'b1);
    chk("R10 still held at winner end", {mem_req, data_rdy}, {1'b0, 3'b001});
    idle();
    strobe(1'b1);
    chk("R10 loser syncs after winner", mem_req, 1'b1);
    idle();
    strobe(1'b0);
    chk("R10 fast_clr ch1", fast_clr, 3'b010);
    idle();
    brk_rq = '0;
    strobe(1'b1);
    idle();
    strobe(1'b0);
    chk("R11 data select ch1", {addr_acc, data_sel}, {3'b010, 3'b010});
    idle();
    strobe(1'b1);
    chk("R6 ch1 input accept", {data_rdy, data_acc}, {3'b010, 3'b010});
    idle();
    chk("R8 sequence ended", {dev_ctl, addr_sel, data_sel, mem_req}, '0);

    finish_run();
  end
endmodule